// File: doc/BRIEF.md
# YCbCr 4:2:2 Parallel Video Formatter

This block turns a stream of 4:2:2 pixel pairs into beats on a 16-bit parallel video bus that carries a frame-valid and a line-valid strobe. Each pair holds two luma samples and one shared pair of chroma samples (Cb, Cr). Each pair arrives on a valid/ready handshake with three markers: start of frame, end of line and end of frame. The formatter holds off its source while it sends the later beats of a pair.

Three packings are available. In the 8-bit and 10-bit packings, each component takes one clock and sits in the upper or lower lane of the bus. In the 16-bit packing, one chroma and one luma sample share each clock. Configuration inputs can swap the two chroma samples and can exchange the luma and chroma positions. This gives four component orders. Every component is limited to the legal video range of the active packing. While line valid is low, the data bus carries zero. The number of clocks between the rise of frame valid and the first line valid is programmable.

A line with an odd pixel count ends on a half pair. That pair carries only its first luma. The formatter completes the 4:2:2 group by sending that luma twice and reusing the chroma of the previous pair in the same line.

Top module: `yuv422_port_fmt`

## Requirements
- R1: With no swap set, the 8-bit and 10-bit packings send a pair as Cb, Y0, Cr, Y1 on four consecutive clocks.
- R2: With chroma swap set, the order is Cr, Y0, Cb, Y1. With luma swap set, it is Y0, Cb, Y1, Cr. With both set, it is Y0, Cr, Y1, Cb. In the 16-bit packing, luma swap moves luma to bits 15:8 and chroma to bits 7:0. Chroma swap makes Cr the chroma of the first beat.
- R3: Packing code 00 selects 8 bits. The component sits on bits 15:8 when MSB alignment is set and on bits 7:0 otherwise. The remaining bus bits are zero.
- R4: Packing code 01 selects 10 bits. The component sits on bits 15:6 when MSB alignment is set and on bits 9:0 otherwise. The remaining bus bits are zero.
- R5: Packing codes 10 and 11 select 16 bits. A pair takes two clocks: first chroma with Y0, then second chroma with Y1. Chroma is on bits 15:8 and luma on bits 7:0 by default. MSB alignment has no effect in this packing.
- R6: In the 8-bit and 16-bit packings, only the low 8 input bits are used. Y is clipped to 16..235 and C to 16..240. In the 10-bit packing, Y is clipped to 64..940 and C to 64..960.
- R7: Whenever line valid is low, the data bus is zero.
- R8: Frame valid stays high with line valid low for exactly the programmed porch (0 to 255 clocks) before the first line valid. A porch of 0 raises both strobes on the same clock.
- R9: An accepted pair appears on the bus on the next clock. Ready stays low during every beat of a pair except the last. When the source keeps valid high, the beats of one line follow each other without gaps.
- R10: A half pair sends its Y0 again in the Y1 slot. It takes its chroma from the previous pair of the same line, or from its own inputs if it is the first pair of the line.
- R11: Line valid is high only inside frame valid. Line valid drops for at least one clock after an end-of-line pair. Frame valid drops after the last beat of the end-of-frame pair. A new frame starts only on a pair marked start of frame.
- R12: After reset, frame valid, line valid and data are zero, and ready is low while start of frame is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack | input | 2 | Packing: 00 8-bit, 01 10-bit, 1x 16-bit |
| cfg_swap_chroma | input | 1 | Exchange Cb and Cr positions |
| cfg_swap_luma | input | 1 | Exchange luma and chroma positions |
| cfg_msb_align | input | 1 | Put narrow components in the upper lane |
| cfg_porch | input | PORCH_W | Clocks between frame valid and first line valid |
| in_valid | input | 1 | Pair available |
| in_ready | output | 1 | Pair taken on this clock when valid |
| in_y0 | input | 10 | First luma sample |
| in_y1 | input | 10 | Second luma sample |
| in_cb | input | 10 | Blue-difference chroma |
| in_cr | input | 10 | Red-difference chroma |
| in_half | input | 1 | Pair carries only its first pixel |
| in_sof | input | 1 | First pair of a frame |
| in_eol | input | 1 | Last pair of a line |
| in_eof | input | 1 | Last pair of a frame |
| vid_fv | output | 1 | Frame valid |
| vid_lv | output | 1 | Line valid |
| vid_data | output | 16 | Parallel video data |

## Verification
Two events can fall on the same clock. The frame-valid rise can coincide with the first data beat when the porch is 0. The end of a line can coincide with the end of a frame on a half pair that reuses chroma. Directed frames force both cases: a zero porch, and lines of a single half pair or of an odd length that close the frame. Random frames mix the swaps, packings, alignments and out-of-range samples. Each bus beat is compared with an expected word that a bench model computes from the order, lane and clip rules. Every clock with line valid low is checked for a zero bus. The porch length is counted from frame-valid rise to line-valid rise.

// File: rtl/yfmt_pkg.sv
package yfmt_pkg;
    localparam int CW     = 10;
    localparam int NARROW = 8;
    localparam int BUS_W  = 16;
    localparam int SLOTS  = 4;
    localparam int BEAT_W = $clog2(SLOTS);

    typedef enum logic [1:0] {PK_8 = 2'd0, PK_10 = 2'd1, PK_16 = 2'd2} pk_e;
    typedef enum logic [1:0] {ST_IDLE, ST_PORCH, ST_SEND, ST_WAIT} st_e;

    typedef logic [CW-1:0] comp_t;

    typedef struct packed {
        comp_t y0;
        comp_t y1;
        comp_t c_a;
        comp_t c_b;
        pk_e   pk;
        logic  swap_l;
        logic  msb;
        logic  eol;
        logic  eof;
    } pair_t;

    function automatic pk_e pk_decode(input logic [1:0] code);
        if (code[1])      return PK_16;
        else if (code[0]) return PK_10;
        else              return PK_8;
    endfunction
endpackage

// File: rtl/yfmt_clip.sv
module yfmt_clip
    import yfmt_pkg::*;
#(
    parameter bit IS_LUMA = 1'b1
) (
    input  comp_t raw,
    input  pk_e   pk,
    output comp_t q
);
    localparam comp_t LO_N = comp_t'(16);
    localparam comp_t HI_N = IS_LUMA ? comp_t'(235) : comp_t'(240);
    localparam comp_t LO_W = comp_t'(64);
    localparam comp_t HI_W = IS_LUMA ? comp_t'(940) : comp_t'(960);

    comp_t lo, hi, v;

    always_comb begin
        if (pk == PK_10) begin
            lo = LO_W;
            hi = HI_W;
            v  = raw;
        end else begin
            lo = LO_N;
            hi = HI_N;
            v  = {{(CW-NARROW){1'b0}}, raw[NARROW-1:0]};
        end
        if (v < lo)      q = lo;
        else if (v > hi) q = hi;
        else             q = v;
    end
endmodule

// File: rtl/yfmt_lane.sv
module yfmt_lane
    import yfmt_pkg::*;
(
    input  pair_t             p,
    input  logic [BEAT_W-1:0] beat,
    output logic [BUS_W-1:0]  bus
);
    comp_t slot [SLOTS];
    comp_t s, c, y;

    always_comb begin
        if (p.swap_l) begin
            slot[0] = p.y0;  slot[1] = p.c_a;
            slot[2] = p.y1;  slot[3] = p.c_b;
        end else begin
            slot[0] = p.c_a; slot[1] = p.y0;
            slot[2] = p.c_b; slot[3] = p.y1;
        end
        s = slot[beat];
        c = beat[0] ? p.c_b : p.c_a;
        y = beat[0] ? p.y1  : p.y0;
        unique case (p.pk)
            PK_10:   bus = p.msb ? {s, {(BUS_W-CW){1'b0}}} : {{(BUS_W-CW){1'b0}}, s};
            PK_16:   bus = p.swap_l ? {y[NARROW-1:0], c[NARROW-1:0]}
                                    : {c[NARROW-1:0], y[NARROW-1:0]};
            default: bus = p.msb ? {s[NARROW-1:0], {(BUS_W-NARROW){1'b0}}}
                                 : {{(BUS_W-NARROW){1'b0}}, s[NARROW-1:0]};
        endcase
    end
endmodule

// File: rtl/yuv422_port_fmt.sv
module yuv422_port_fmt
    import yfmt_pkg::*;
#(
    parameter int PORCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_pack,
    input  logic               cfg_swap_chroma,
    input  logic               cfg_swap_luma,
    input  logic               cfg_msb_align,
    input  logic [PORCH_W-1:0] cfg_porch,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CW-1:0]      in_y0,
    input  logic [CW-1:0]      in_y1,
    input  logic [CW-1:0]      in_cb,
    input  logic [CW-1:0]      in_cr,
    input  logic               in_half,
    input  logic               in_sof,
    input  logic               in_eol,
    input  logic               in_eof,
    output logic               vid_fv,
    output logic               vid_lv,
    output logic [BUS_W-1:0]   vid_data
);
    localparam int NCOMP = 4;

    typedef struct packed {
        st_e               st;
        logic [PORCH_W-1:0] cnt;
        pair_t             pair;
        logic [BEAT_W-1:0] beat;
        comp_t             prev_cb;
        comp_t             prev_cr;
        logic              line_open;
        logic              fv;
        logic              lv;
    } regs_t;

    regs_t q, d;
    logic [BUS_W-1:0] data_d, data_q, lane_bus;

    pk_e   in_pk;
    comp_t raw_c  [NCOMP];
    comp_t clip_c [NCOMP];
    comp_t cb_sel, cr_sel;
    pair_t new_pair;
    logic  last_beat, rdy, accept, use_prev;

    assign in_pk    = pk_decode(cfg_pack);
    assign raw_c[0] = in_y0;
    assign raw_c[1] = in_half ? in_y0 : in_y1;
    assign raw_c[2] = in_cb;
    assign raw_c[3] = in_cr;

    for (genvar gi = 0; gi < NCOMP; gi++) begin : g_clip
        yfmt_clip #(.IS_LUMA(gi < 2 ? 1'b1 : 1'b0)) u_clip (
            .raw (raw_c[gi]),
            .pk  (in_pk),
            .q   (clip_c[gi])
        );
    end

    always_comb begin
        use_prev = in_half && q.line_open;
        cb_sel   = use_prev ? q.prev_cb : clip_c[2];
        cr_sel   = use_prev ? q.prev_cr : clip_c[3];
        new_pair = '{y0: clip_c[0], y1: clip_c[1],
                     c_a: cfg_swap_chroma ? cr_sel : cb_sel,
                     c_b: cfg_swap_chroma ? cb_sel : cr_sel,
                     pk: in_pk, swap_l: cfg_swap_luma, msb: cfg_msb_align,
                     eol: in_eol, eof: in_eof};
        last_beat = (q.pair.pk == PK_16) ? (q.beat == BEAT_W'(1))
                                         : (q.beat == BEAT_W'(SLOTS-1));
        unique case (q.st)
            ST_IDLE:  rdy = in_sof && (cfg_porch == '0);
            ST_PORCH: rdy = (q.cnt == '0);
            ST_SEND:  rdy = last_beat && !q.pair.eol;
            default:  rdy = 1'b1;
        endcase
        accept = in_valid && rdy;
    end

    assign in_ready = rdy;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid && in_sof && cfg_porch != '0) begin
                    d.st  = ST_PORCH;
                    d.cnt = cfg_porch - 1'b1;
                    d.fv  = 1'b1;
                end
            end
            ST_PORCH: begin
                if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
            end
            ST_SEND: begin
                if (!last_beat) begin
                    d.beat = q.beat + 1'b1;
                end else if (q.pair.eol) begin
                    d.lv        = 1'b0;
                    d.line_open = 1'b0;
                    if (q.pair.eof) begin
                        d.st = ST_IDLE;
                        d.fv = 1'b0;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end else begin
                    d.st = ST_WAIT;
                    d.lv = 1'b0;
                end
            end
            default: ;
        endcase
        if (accept) begin
            d.st        = ST_SEND;
            d.pair      = new_pair;
            d.beat      = '0;
            d.fv        = 1'b1;
            d.lv        = 1'b1;
            d.prev_cb   = cb_sel;
            d.prev_cr   = cr_sel;
            d.line_open = 1'b1;
        end
    end

    yfmt_lane u_lane (
        .p    (d.pair),
        .beat (d.beat),
        .bus  (lane_bus)
    );

    assign data_d = d.lv ? lane_bus : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            data_q <= '0;
        end else begin
            q      <= d;
            data_q <= data_d;
        end
    end

    assign vid_fv   = q.fv;
    assign vid_lv   = q.lv;
    assign vid_data = data_q;

    AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
        vid_lv |-> vid_fv); // R11
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_lv |-> (vid_data == '0)); // R7
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (vid_lv && vid_fv)); // R9
    AST_MIDPAIR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND && q.beat == '0) |-> !in_ready); // R9
    AST_PORCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vid_fv) && $past(cfg_porch) != '0) |-> !vid_lv); // R8
    AST_NARROW_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_lv && q.pair.pk == PK_8 && !q.pair.msb) |-> (vid_data[15:8] == '0)); // R3
endmodule

// File: tb/yuv422_port_fmt_tb.sv
module yuv422_port_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_pack = 2'd0;
    logic        cfg_swap_chroma = 1'b0, cfg_swap_luma = 1'b0, cfg_msb_align = 1'b0;
    logic [7:0]  cfg_porch = 8'd0;
    logic        in_valid = 1'b0, in_ready;
    logic [9:0]  in_y0 = '0, in_y1 = '0, in_cb = '0, in_cr = '0;
    logic        in_half = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
    logic        vid_fv, vid_lv;
    logic [15:0] vid_data;

    int errs = 0, checks = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int  exp_porch = 0;
    int  prev_cb = 0, prev_cr = 0;
    bit  open_b = 0;
    bit  prev_fv = 0, counting = 0;
    int  porch_cnt = 0;

    always #5 clk = ~clk;

    yuv422_port_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack),
        .cfg_swap_chroma(cfg_swap_chroma), .cfg_swap_luma(cfg_swap_luma),
        .cfg_msb_align(cfg_msb_align), .cfg_porch(cfg_porch),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y0(in_y0), .in_y1(in_y1), .in_cb(in_cb), .in_cr(in_cr),
        .in_half(in_half), .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
        .vid_fv(vid_fv), .vid_lv(vid_lv), .vid_data(vid_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clipf(input int v, input bit luma, input int pk);
        int lo, hi, x;
        if (pk == 1) begin lo = 64; hi = luma ? 940 : 960; x = v; end
        else begin lo = 16; hi = luma ? 235 : 240; x = v & 255; end
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic int lanef(input int v, input int pk, input bit msb);
        if (pk == 1) return msb ? ((v << 6) & 16'hFFFF) : v;
        return msb ? ((v & 255) << 8) : (v & 255);
    endfunction

    task automatic model_pair(input int y0, input int y1, input int cb, input int cr, input bit half);
        int pk, cy0, cy1, ccb, ccr, fa, fb;
        int seq[4];
        bit clipped;
        string t;
        pk  = cfg_pack[1] ? 2 : (cfg_pack[0] ? 1 : 0);
        cy0 = clipf(y0, 1, pk);
        cy1 = half ? cy0 : clipf(y1, 1, pk);
        ccb = (half && open_b) ? prev_cb : clipf(cb, 0, pk);
        ccr = (half && open_b) ? prev_cr : clipf(cr, 0, pk);
        clipped = (cy0 != (pk == 1 ? y0 : (y0 & 255)));
        prev_cb = ccb; prev_cr = ccr; open_b = 1;
        t = (pk == 0) ? "R3" : ((pk == 1) ? "R4" : "R5");
        t = {t, (cfg_swap_chroma || cfg_swap_luma) ? " R2" : " R1"};
        if (clipped) t = {t, " R6"};
        if (half) t = {t, " R10"};
        fa = cfg_swap_chroma ? ccr : ccb;
        fb = cfg_swap_chroma ? ccb : ccr;
        if (pk == 2) begin
            exp_q.push_back(16'(cfg_swap_luma ? (((cy0 & 255) << 8) | (fa & 255)) : (((fa & 255) << 8) | (cy0 & 255))));
            exp_q.push_back(16'(cfg_swap_luma ? (((cy1 & 255) << 8) | (fb & 255)) : (((fb & 255) << 8) | (cy1 & 255))));
            tag_q.push_back(t); tag_q.push_back(t);
        end else begin
            if (cfg_swap_luma) begin seq[0] = cy0; seq[1] = fa; seq[2] = cy1; seq[3] = fb; end
            else begin seq[0] = fa; seq[1] = cy0; seq[2] = fb; seq[3] = cy1; end
            for (int k = 0; k < 4; k++) begin
                exp_q.push_back(16'(lanef(seq[k], pk, cfg_msb_align)));
                tag_q.push_back(t);
            end
        end
    endtask

    function automatic int rnd_comp();
        int r;
        r = $urandom_range(0, 3);
        if (r == 0) return 0;
        if (r == 1) return 1023;
        return $urandom_range(0, 1023);
    endfunction

    task automatic push_pair(input bit half, input bit sof, input bit eol, input bit eof);
        int y0, y1, cb, cr, nb;
        bit r;
        y0 = rnd_comp(); y1 = rnd_comp(); cb = rnd_comp(); cr = rnd_comp();
        in_valid = 1'b1; in_y0 = 10'(y0); in_y1 = 10'(y1); in_cb = 10'(cb); in_cr = 10'(cr);
        in_half = half; in_sof = sof; in_eol = eol; in_eof = eof;
        forever begin
            #1;
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        model_pair(y0, y1, cb, cr, half);
        if (eol) open_b = 0;
        nb = cfg_pack[1] ? 1 : 3;
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            #1;
            chk(in_ready == 1'b0, "R9 ready low mid-pair", int'(in_ready), 0);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input int nl, input int np, input bit odd, input int porch,
                              input int pk, input bit sc, input bit sl, input bit msb);
        cfg_pack = 2'(pk); cfg_swap_chroma = sc; cfg_swap_luma = sl;
        cfg_msb_align = msb; cfg_porch = 8'(porch);
        exp_porch = porch;
        open_b = 0;
        for (int l = 0; l < nl; l++) begin
            for (int p = 0; p < np; p++) begin
                push_pair(odd && (p == np - 1), (l == 0) && (p == 0), p == np - 1,
                          (l == nl - 1) && (p == np - 1));
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0; in_half = 1'b0;
        while (vid_fv) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (vid_fv && !prev_fv) begin
                counting  = 1;
                porch_cnt = 0;
            end
            if (counting) begin
                if (!vid_lv) porch_cnt++;
                else begin
                    chk(porch_cnt == exp_porch, "R8 porch length", porch_cnt, exp_porch);
                    counting = 0;
                end
            end
            if (vid_lv) begin
                chk(vid_fv == 1'b1, "R11 line valid inside frame valid", int'(vid_fv), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected beat", int'(vid_data), 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(vid_data == e, t, int'(vid_data), int'(e));
                end
            end else begin
                chk(vid_data == 16'h0, "R7 blanking data", int'(vid_data), 0);
            end
            if (!vid_fv && prev_fv)
                chk(exp_q.size() == 0, "R11 beats left at frame end", exp_q.size(), 0);
            prev_fv = vid_fv;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(vid_fv == 1'b0,    "R12 reset frame valid", int'(vid_fv), 0);
        chk(vid_lv == 1'b0,    "R12 reset line valid", int'(vid_lv), 0);
        chk(vid_data == 16'h0, "R12 reset data", int'(vid_data), 0);
        chk(in_ready == 1'b0,  "R12 ready without start of frame", int'(in_ready), 0);
        // R11: a pair without start of frame is not taken while idle
        in_valid = 1'b1; in_sof = 1'b0;
        repeat (3) @(negedge clk);
        chk(vid_fv == 1'b0, "R11 no frame without start marker", int'(vid_fv), 0);
        in_valid = 1'b0;
        @(negedge clk);
        // directed corners
        send_frame(1, 2, 0, 0,   0, 0, 0, 1); // R1 R3 R8 zero porch
        send_frame(2, 2, 0, 3,   1, 1, 0, 0); // R2 R4
        send_frame(1, 3, 1, 255, 2, 1, 1, 0); // R5 R8 R10 max porch
        send_frame(2, 1, 1, 1,   0, 0, 1, 0); // R10 half pair first in line
        send_frame(1, 2, 1, 0,   3, 0, 0, 1); // R5 code 11, R10 at frame end
        send_frame(2, 3, 1, 2,   1, 1, 1, 1); // R2 R4 R10
        for (int f = 0; f < 24; f++) begin
            send_frame($urandom_range(1, 3), $urandom_range(1, 4), 1'($urandom_range(0, 1)),
                       $urandom_range(0, 20), $urandom_range(0, 3),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule